// File: doc/BRIEF.md
# Latched Output Expander Controller

This block multiplies a handful of pins into many output-only lines. It drives a bank of external edge-triggered latches. All the latches share one set of data wires, and each latch has its own clock strobe. The block holds a shadow image of every output line. A host writes one line at a time by giving a line index and a bit value.

For each accepted write, the controller works in this order:
1. It updates the shadow image.
2. It places the whole group of the affected latch on the shared data wires.
3. It waits a programmable setup time.
4. It pulses the strobe of that latch for a programmable width.

While an update is in progress, a valid/ready handshake holds off further writes. The shape of the bank is set at synthesis time by two parameters: the number of latches and the number of data wires per latch. The two intervals are given in nanoseconds and converted to clock cycles using a clock-period parameter.

Top module: `lx_expander`

## Requirements
- R1: After reset, every strobe output, every data output and `err_o` are low, and `wr_ready_o` is high. Every shadow bit is zero, so a first write of a single 1 shows that bit alone set in its group.
- R2: An accepted write with index `k` below `N_LATCH*N_DATA` changes only shadow bit `k`. All other bits of the group driven on `data_o` keep their earlier values.
- R3: The target latch of index `k` is `k / N_DATA` (integer division). Only `strobe_o[k / N_DATA]` pulses. `data_o[j]` carries shadow bit `(k / N_DATA)*N_DATA + j`.
- R4: `data_o` takes its new value on the acceptance edge and stays stable through the strobe pulse. The strobe rises on the edge `S+1` cycles after the acceptance edge, where `S = floor(min(setup_ns_i, 5000) / CLK_PERIOD_NS)`.
- R5: The strobe stays high for exactly `P` cycles, where `P = max(1, floor(min(strobe_ns_i, 5000) / CLK_PERIOD_NS))`. A setting of zero gives one cycle.
- R6: Interval settings above 5000 ns act as 5000 ns. Both settings are sampled at acceptance.
- R7: `wr_ready_o` is low from the acceptance edge of an in-range write until the edge on which the strobe falls. On that edge it returns high, so updates never overlap.
- R8: A write with an index at or above `N_LATCH*N_DATA` is accepted while ready and leaves the shadow unchanged. It raises `err_o` for the single following cycle, with no strobe activity, `data_o` unchanged and `wr_ready_o` still high.
- R9: `dir_out_o` reports every line as an output (all ones) at all times.
- R10: At most one strobe output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write request |
| wr_ready_o | output | 1 | Controller idle and able to accept a write |
| wr_idx_i | input | IDX_W = clog2(N_LATCH*N_DATA)+1 | Line index of the write |
| wr_bit_i | input | 1 | Value written to the line |
| setup_ns_i | input | NS_W | Data-to-strobe setup time in ns |
| strobe_ns_i | input | NS_W | Strobe high time in ns |
| data_o | output | N_DATA | Shared latch data wires |
| strobe_o | output | N_LATCH | One clock strobe per latch |
| err_o | output | 1 | One-cycle flag for an out-of-range index |
| dir_out_o | output | N_LATCH*N_DATA | Direction report, 1 = output |

## Verification
The properties take for granted a few things about the inputs:
- Reset is applied before the first write.
- Every input carries a known value on each edge.
- The host treats `valid && ready` on a clock edge as the one and only acceptance of a write.

The bench drives all inputs on falling edges. It keeps the index, value and both settings constant while valid is high, and it drops valid on the first falling edge after acceptance, so every write is taken exactly once. Interval settings stay in the tens of nanoseconds, except for one write that tests the 5000 ns clamp. This keeps each update short, and every update finishes before the next is offered.

// File: rtl/lx_pkg.sv
package lx_pkg;
  localparam int unsigned MAX_NS = 5000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2
  } lx_state_e;
endpackage

// File: rtl/lx_interval.sv
// Clamp an ns setting to MAX_NS and convert to whole clock cycles.
module lx_interval #(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned NS_W          = 16,
  parameter int unsigned CNT_W         = 13,
  parameter bit          MIN_ONE       = 1'b0
) (
  input  logic [NS_W-1:0]  ns_i,
  output logic [CNT_W-1:0] cyc_o
);
  import lx_pkg::*;

  logic [NS_W-1:0] clamp_ns;
  logic [NS_W-1:0] quot;

  always_comb begin
    clamp_ns = (ns_i > NS_W'(MAX_NS)) ? NS_W'(MAX_NS) : ns_i;
    quot     = clamp_ns / NS_W'(CLK_PERIOD_NS);
    if (MIN_ONE && quot == '0) quot = NS_W'(1);
    cyc_o    = quot[CNT_W-1:0];
  end
endmodule

// File: rtl/lx_shadow.sv
// Shadow image of all lines; presents the updated group of a selected latch.
module lx_shadow #(
  parameter int unsigned N_LATCH = 2,
  parameter int unsigned N_DATA  = 8,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned LAT_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bit_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic [N_DATA-1:0] grp_nx_o
);
  localparam int unsigned N_LINES = N_LATCH * N_DATA;

  logic [N_LINES-1:0] shadow_q;
  logic [N_LINES-1:0] shadow_nx;

  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    assign shadow_nx[g] = (we_i && idx_i == IDX_W'(g)) ? bit_i : shadow_q[g];
  end

  always_comb begin
    for (int j = 0; j < N_DATA; j++) begin
      grp_nx_o[j] = shadow_nx[int'(lat_i) * N_DATA + j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else         shadow_q <= shadow_nx;
  end
endmodule

// File: rtl/lx_expander.sv
module lx_expander #(
  parameter int unsigned N_LATCH       = 2,
  parameter int unsigned N_DATA        = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned NS_W          = 16,
  localparam int unsigned N_LINES      = N_LATCH * N_DATA,
  localparam int unsigned IDX_W        = $clog2(N_LINES) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_bit_i,
  input  logic [NS_W-1:0]    setup_ns_i,
  input  logic [NS_W-1:0]    strobe_ns_i,
  output logic [N_DATA-1:0]  data_o,
  output logic [N_LATCH-1:0] strobe_o,
  output logic               err_o,
  output logic [N_LINES-1:0] dir_out_o
);
  import lx_pkg::*;

  localparam int unsigned LAT_W = (N_LATCH > 1) ? $clog2(N_LATCH) : 1;
  localparam int unsigned CNT_W = $clog2(MAX_NS + 1);

  lx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   str_q;
  logic [LAT_W-1:0]   lat_q;
  logic [CNT_W-1:0]   set_cyc;
  logic [CNT_W-1:0]   str_cyc;
  logic [N_DATA-1:0]  grp_nx;
  logic [IDX_W-1:0]   tgt_full;
  logic [LAT_W-1:0]   tgt;
  logic               in_range;
  logic               accept;
  logic               wr_en;

  assign dir_out_o  = '1;
  assign wr_ready_o = (state_q == ST_IDLE);
  assign in_range   = wr_idx_i < IDX_W'(N_LINES);
  assign accept     = wr_valid_i && wr_ready_o;
  assign wr_en      = accept && in_range;
  assign tgt_full   = wr_idx_i / IDX_W'(N_DATA);
  assign tgt        = tgt_full[LAT_W-1:0];

  lx_interval #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .NS_W(NS_W), .CNT_W(CNT_W), .MIN_ONE(1'b0)
  ) u_setup (
    .ns_i (setup_ns_i),
    .cyc_o(set_cyc)
  );

  lx_interval #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .NS_W(NS_W), .CNT_W(CNT_W), .MIN_ONE(1'b1)
  ) u_strobe (
    .ns_i (strobe_ns_i),
    .cyc_o(str_cyc)
  );

  lx_shadow #(
    .N_LATCH(N_LATCH), .N_DATA(N_DATA), .IDX_W(IDX_W), .LAT_W(LAT_W)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .idx_i   (wr_idx_i),
    .bit_i   (wr_bit_i),
    .lat_i   (tgt),
    .grp_nx_o(grp_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      str_q    <= '0;
      lat_q    <= '0;
      data_o   <= '0;
      strobe_o <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (in_range) begin
              data_o  <= grp_nx;
              lat_q   <= tgt;
              cnt_q   <= set_cyc;
              str_q   <= str_cyc;
              state_q <= ST_SETUP;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            strobe_o <= N_LATCH'(1) << lat_q;
            cnt_q    <= str_q - CNT_W'(1);
            state_q  <= ST_PULSE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_PULSE: begin
          if (cnt_q == '0) begin
            strobe_o <= '0;
            state_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lx_chk.sv
module lx_chk #(
  parameter int unsigned N_LATCH = 2,
  parameter int unsigned N_DATA  = 8,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic               wr_ready_o,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [N_DATA-1:0]  data_o,
  input logic [N_LATCH-1:0] strobe_o,
  input logic               err_o
);
  localparam int unsigned N_LINES = N_LATCH * N_DATA;

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  p_busy_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> !wr_ready_o);

  p_accept_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_idx_i < IDX_W'(N_LINES)) |=> !wr_ready_o);

  p_ready_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|strobe_o) |-> wr_ready_o);

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> $stable(data_o));

  p_bad_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_idx_i >= IDX_W'(N_LINES))
      |=> (err_o && wr_ready_o && strobe_o == '0 && $stable(data_o)));

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_valid_i && wr_ready_o && wr_idx_i >= IDX_W'(N_LINES)));
endmodule

bind lx_expander lx_chk #(
  .N_LATCH(N_LATCH), .N_DATA(N_DATA), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_ready_o(wr_ready_o),
  .wr_idx_i  (wr_idx_i),
  .data_o    (data_o),
  .strobe_o  (strobe_o),
  .err_o     (err_o)
);

// File: tb/sim_lx_expander.sv
`timescale 1ns/1ps
module sim_lx_expander;
  localparam int N_LATCH = 2;
  localparam int N_DATA  = 8;
  localparam int N_LINES = N_LATCH * N_DATA;
  localparam int IDX_W   = $clog2(N_LINES) + 1;
  localparam int T_NS    = 4;

  typedef struct {
    int     latch;
    int     data;
    int     s;
    int     p;
    bit     err;
    longint acc;
  } item_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_valid = 1'b0;
  logic               wr_ready;
  logic [IDX_W-1:0]   wr_idx = '0;
  logic               wr_bit = 1'b0;
  logic [15:0]        setup_ns = '0;
  logic [15:0]        strobe_ns = '0;
  logic [N_DATA-1:0]  data;
  logic [N_LATCH-1:0] strobe;
  logic               err;
  logic [N_LINES-1:0] dir_out;

  int     n_run = 0;
  int     n_fail = 0;
  longint cyc = 0;
  item_t  q[$];
  logic [N_LINES-1:0] model = '0;
  int     last_data = 0;
  bit     finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lx_expander #(.N_LATCH(N_LATCH), .N_DATA(N_DATA), .CLK_PERIOD_NS(T_NS), .NS_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_idx_i(wr_idx), .wr_bit_i(wr_bit), .setup_ns_i(setup_ns), .strobe_ns_i(strobe_ns),
    .data_o(data), .strobe_o(strobe), .err_o(err), .dir_out_o(dir_out)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int cyc_of(int ns);
    int c = (ns > 5000) ? 5000 : ns;
    return c / T_NS;
  endfunction

  task automatic do_write(int idx, bit v, int su, int st);
    item_t it;
    @(negedge clk);
    wr_valid  = 1'b1;
    wr_idx    = IDX_W'(idx);
    wr_bit    = v;
    setup_ns  = 16'(su);
    strobe_ns = 16'(st);
    while (!wr_ready) @(negedge clk);
    it.err = (idx >= N_LINES);
    it.acc = cyc + 1;
    it.s   = cyc_of(su);
    it.p   = (cyc_of(st) == 0) ? 1 : cyc_of(st);
    if (!it.err) begin
      model[idx] = v;
      it.latch   = idx / N_DATA;
      last_data  = int'((model >> (it.latch * N_DATA)) & N_LINES'((1 << N_DATA) - 1));
    end else begin
      it.latch = 0;
    end
    it.data = last_data;
    q.push_back(it);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Monitor: pops expected items as strobe pulses and error flags appear.
  bit     in_pulse = 1'b0;
  int     hi_cnt = 0;
  item_t  cur;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(dir_out == '1, "R9 direction", dir_out, '1);
      if (!in_pulse && strobe != '0) begin
        if (q.size() == 0) chk(1'b0, "R3 unexpected strobe", strobe, 0);
        else begin
          cur = q.pop_front();
          chk(!cur.err, "R8 strobe on bad index", 1, 0);
          chk(strobe == N_LATCH'(1 << cur.latch), "R3 target strobe", strobe, 1 << cur.latch);
          chk(int'(data) == cur.data, "R2 data group", data, cur.data);
          chk(cyc == cur.acc + cur.s + 1, "R4 strobe rise cycle", cyc, cur.acc + cur.s + 1);
          chk(!wr_ready, "R7 ready low in pulse", wr_ready, 0);
          in_pulse = 1'b1;
          hi_cnt   = 1;
        end
      end else if (in_pulse && strobe != '0) begin
        hi_cnt++;
        if (!((int'(data) == cur.data) && !wr_ready))
          chk(1'b0, "R4 data/ready stable in pulse", data, cur.data);
      end else if (in_pulse && strobe == '0) begin
        chk(hi_cnt == cur.p, "R5 strobe width", hi_cnt, cur.p);
        chk(wr_ready, "R7 ready after fall", wr_ready, 1);
        in_pulse = 1'b0;
      end
      if (err) begin
        if (q.size() == 0) chk(1'b0, "R8 unexpected err", 1, 0);
        else begin
          cur = q.pop_front();
          chk(cur.err, "R8 err on good index", 1, 0);
          chk(cyc == cur.acc, "R8 err cycle", cyc, cur.acc);
          chk(strobe == '0, "R8 no strobe", strobe, 0);
          chk(int'(data) == cur.data, "R8 data unchanged", data, cur.data);
          chk(wr_ready, "R8 ready stays high", wr_ready, 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe == '0, "R1 strobe reset", strobe, 0);
    chk(data == '0, "R1 data reset", data, 0);
    chk(!err, "R1 err reset", err, 0);
    chk(wr_ready, "R1 ready reset", wr_ready, 1);

    do_write(3, 1'b1, 20, 12);      // R1: lone bit in zeroed shadow
    do_write(12, 1'b1, 0, 0);       // R3 latch 1, R5 zero width -> 1
    do_write(5, 1'b1, 7, 9);        // R2 keep bit 3
    do_write(3, 1'b0, 4, 4);
    do_write(16, 1'b1, 8, 8);       // R8
    do_write(31, 1'b0, 8, 8);       // R8
    do_write(15, 1'b1, 9999, 6000); // R6 clamp
    for (int i = 0; i < N_LINES; i++) do_write(i, 1'b1, (i % 3) * 4, 4 + (i % 2) * 8);
    for (int i = 0; i < N_LINES; i += 3) do_write(i, 1'b0, 4, 4);
    do_write(20, 1'b1, 0, 0);
    do_write(9, 1'b0, 12, 16);

    wait (q.size() == 0 && !in_pulse && wr_ready);
    repeat (4) @(negedge clk);
    chk(strobe == '0 && !err, "R10 idle at end", strobe, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule